// File: doc/BRIEF.md
# Sprite Attribute Table DMA Engine

This engine copies one fixed block of sprite attribute data, forty entries of four bytes (160 bytes), from main memory into a small attribute memory. Software starts a copy with a single register write. The written byte becomes the high byte of the source address, so a source block always begins on a 256-byte page boundary. The destination is the whole attribute window, offsets 00h to 9Fh.

While the copy runs, the engine drives a read request on a generic memory port and waits for that port's ready signal before it takes each byte. One cycle after the read is accepted, it writes that byte into the attribute memory at the same offset as the source low byte. A busy flag covers the whole copy. Other bus masters use it to hold off their own accesses. Arbitration beyond that flag is left to the system.

Top module: `attr_dma`

## Requirements
- R1: During reset and after reset release, busy, mem_req and atr_we are low.
- R2: A register write whose value lies in the page window 80h to DFh starts a copy. Busy and mem_req are high in the next cycle, and the first read address is {page, 00h}.
- R3: A register write whose value lies outside 80h to DFh is ignored. When idle, busy stays low and no attribute write occurs. During a copy, the copy continues with its original page and completes normally.
- R4: A copy makes exactly 160 attribute writes. The offsets run from 00h to 9Fh in ascending order, and each written byte equals the memory byte read at address {page, offset}.
- R5: A read advances only in a cycle where mem_ready is high. While mem_ready is low, mem_addr holds its value, and no byte is lost or duplicated.
- R6: Busy falls in the cycle after the write of offset 9Fh. With mem_ready held high, busy is high for exactly 161 cycles.
- R7: A valid register write during a copy restarts the copy from offset 00h with the new page. Any read accepted in the restart cycle is discarded.
- R8: mem_req is high only while busy, and it is low once busy has fallen. The low byte of mem_addr always equals the offset that will be written next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Source page number written to the start register |
| mem_req | output | 1 | Read request to main memory |
| mem_addr | output | 16 | Read address, {page, offset} |
| mem_ready | input | 1 | Memory has valid data for the current address |
| mem_rdata | input | 8 | Read data |
| atr_we | output | 1 | Attribute memory write strobe |
| atr_addr | output | 8 | Attribute memory offset |
| atr_wdata | output | 8 | Attribute memory write data |
| busy | output | 1 | Copy in progress |

## Verification
The bench builds the engine with its default parameters: a 16-bit address, an 8-bit page, a 80h to DFh window and forty 4-byte entries. With these values, the 9Fh end offset and both edges of the page window (7Fh, 80h, DFh, E0h) can be reached directly. The memory model returns a byte computed from the full address, so a wrong page or offset shows up in the written data. Wait states come from a programmable ready pattern, including one that holds ready low. This exercises the stall path, a restart in the middle of a copy and an ignored write in the middle of a copy.

// File: rtl/attr_dma_pkg.sv
package attr_dma_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/attr_dma_rst_sync.sv
module attr_dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/attr_dma_start.sv
module attr_dma_start #(
  parameter int unsigned       PAGE_W  = 8,
  parameter logic [PAGE_W-1:0] PAGE_LO = 8'h80,
  parameter logic [PAGE_W-1:0] PAGE_HI = 8'hDF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic              start,
  output logic [PAGE_W-1:0] page_q
);
  logic              page_ok;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_ok = (cfg_wdata >= PAGE_LO) && (cfg_wdata <= PAGE_HI);
    start   = cfg_we && page_ok;
    page_d  = page_q;
    if (start) begin
      page_d = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
    end else begin
      page_q <= page_d;
    end
  end

  // R2: the latched page always lies inside the window after a start
  p_page_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((page_q >= PAGE_LO) && (page_q <= PAGE_HI)));

  // R3: a rejected write leaves the page untouched
  p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !start) |=> $stable(page_q));
endmodule

// File: rtl/attr_dma_seq.sv
module attr_dma_seq
  import attr_dma_pkg::*;
#(
  parameter int unsigned COUNT_W = 8,
  parameter int unsigned BEATS   = 160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mem_ready,
  output logic               active,
  output logic               accept,
  output logic [COUNT_W-1:0] idx
);
  localparam logic [COUNT_W-1:0] LAST = COUNT_W'(BEATS - 1);

  seq_state_e         state_q, state_d;
  logic [COUNT_W-1:0] idx_d;
  logic               idx_en;

  always_comb begin
    active  = (state_q == SEQ_RUN);
    accept  = active && mem_ready && !start;
    state_d = state_q;
    idx_d   = idx;
    idx_en  = 1'b0;
    if (start) begin
      state_d = SEQ_RUN;
      idx_d   = '0;
      idx_en  = 1'b1;
    end else if (accept) begin
      if (idx == LAST) begin
        state_d = SEQ_IDLE;
      end else begin
        idx_d  = idx + 1'b1;
        idx_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end

  // R4: the offset never runs past the last byte while running
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= LAST));

  // R5: a stalled read holds both the offset and the running state
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mem_ready && !start) |=> (active && $stable(idx)));

  // R7: any start leads to a running copy at offset zero
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && (idx == '0)));
endmodule

// File: rtl/attr_dma_wr.sv
module attr_dma_wr #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OFF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [DATA_W-1:0] rd_data,
  output logic              we,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we <= 1'b0;
    end else begin
      we <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_off  <= '0;
      wr_data <= '0;
    end else if (accept) begin
      wr_off  <= rd_off;
      wr_data <= rd_data;
    end
  end

  // R4: offsets of back-to-back writes ascend by one
  p_wr_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && accept) |=> (wr_off == $past(wr_off) + 1'b1));
endmodule

// File: rtl/attr_dma.sv
module attr_dma #(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       PAGE_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ENTRIES     = 40,
  parameter int unsigned       ENTRY_BYTES = 4,
  parameter logic [PAGE_W-1:0] PAGE_LO     = 8'h80,
  parameter logic [PAGE_W-1:0] PAGE_HI     = 8'hDF,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [PAGE_W-1:0]       cfg_wdata,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_ready,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    atr_we,
  output logic [ADDR_W-PAGE_W-1:0] atr_addr,
  output logic [DATA_W-1:0]       atr_wdata,
  output logic                    busy
);
  localparam int unsigned       OFF_W = ADDR_W - PAGE_W;
  localparam int unsigned       BEATS = ENTRIES * ENTRY_BYTES;
  localparam logic [OFF_W-1:0]  LAST  = OFF_W'(BEATS - 1);

  logic              rst_q;
  logic              start;
  logic [PAGE_W-1:0] page_q;
  logic              active;
  logic              accept;
  logic [OFF_W-1:0]  idx;

  attr_dma_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  attr_dma_start #(.PAGE_W(PAGE_W), .PAGE_LO(PAGE_LO), .PAGE_HI(PAGE_HI)) u_start (
    .clk       (clk),
    .rst_n     (rst_q),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .start     (start),
    .page_q    (page_q)
  );

  attr_dma_seq #(.COUNT_W(OFF_W), .BEATS(BEATS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .start     (start),
    .mem_ready (mem_ready),
    .active    (active),
    .accept    (accept),
    .idx       (idx)
  );

  attr_dma_wr #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_q),
    .accept  (accept),
    .rd_off  (idx),
    .rd_data (mem_rdata),
    .we      (atr_we),
    .wr_off  (atr_addr),
    .wr_data (atr_wdata)
  );

  always_comb begin
    mem_req  = active;
    mem_addr = {page_q, idx};
    busy     = active || atr_we;
  end

  // R2: a valid start raises busy with the read at the page base
  p_busy_next_r2: assert property (@(posedge clk) disable iff (!rst_q)
    start |=> (busy && mem_req && (mem_addr[OFF_W-1:0] == '0)));

  // R3: a rejected write while idle keeps the engine idle
  p_ignore_idle_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_we && !start && !busy) |=> !busy);

  // R5: every attribute write follows an accepted read
  p_wr_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_q)
    atr_we |-> $past(mem_req && mem_ready));

  // R6: busy falls only right after the last offset is written
  p_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(busy) |-> ($past(atr_we) && ($past(atr_addr) == LAST)));

  // R8: no read request outside busy
  p_req_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_q)
    mem_req |-> busy);
endmodule

// File: tb/attr_dma_bench.sv
`timescale 1ns/1ps
module attr_dma_bench;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ready;
  logic [7:0]  mem_rdata;
  logic        atr_we;
  logic [7:0]  atr_addr;
  logic [7:0]  atr_wdata;
  logic        busy;

  int errors = 0;
  int checks = 0;

  int         stall = 0;
  int         rcnt = 0;
  logic [7:0] exp_page = 8'h00;
  int         exp_idx = 0;
  int         wr_cnt = 0;
  int         bad = 0;
  int         bad_addr = 0;
  int         bad_data = 0;
  int         busy_cyc = 0;

  attr_dma u_attr_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .atr_we    (atr_we),
    .atr_addr  (atr_addr),
    .atr_wdata (atr_wdata),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  // ready pattern: 0 = always, 15 = held low, n = one cycle in n+1
  always @(negedge clk) begin
    if (stall == 15) begin
      mem_ready = 1'b0;
    end else if (stall == 0) begin
      mem_ready = 1'b1;
    end else begin
      mem_ready = (rcnt == 0);
      rcnt = (rcnt >= stall) ? 0 : rcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (atr_we) begin
      if ((int'(atr_addr) != exp_idx) ||
          (atr_wdata != mem_byte({exp_page, 8'(exp_idx)}))) begin
        if (bad == 0) begin
          bad_addr = int'(atr_addr);
          bad_data = int'(atr_wdata);
        end
        bad++;
      end
      exp_idx++;
      wr_cnt++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic write_valid(input logic [7:0] page);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = page;
    @(posedge clk);
    #1;
    exp_page = page;
    exp_idx = 0;
    wr_cnt = 0;
    bad = 0;
    busy_cyc = 0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_raw(input logic [7:0] page);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = page;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    #1;
  endtask

  task automatic check_copy(input string req, input logic [7:0] page);
    check(wr_cnt == 160, {req, " write count"}, wr_cnt, 160);
    check(bad == 0, {req, " offset/data"}, (bad_addr << 8) | bad_data,
          (bad_addr << 8) | int'(mem_byte({page, 8'(bad_addr)})));
    check(!mem_req, "R8 req low after busy", int'(mem_req), 0);
  endtask

  // {page, stall pattern, start expected}
  localparam logic [12:0] VEC [7] = '{
    {8'h80, 4'd0, 1'b1},
    {8'hDF, 4'd2, 1'b1},
    {8'h7F, 4'd0, 1'b0},
    {8'hE0, 4'd1, 1'b0},
    {8'hA5, 4'd3, 1'b1},
    {8'h00, 4'd0, 1'b0},
    {8'hC3, 4'd1, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = 8'h00;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req && !atr_we, "R1 in reset",
          {busy, mem_req, atr_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req && !atr_we, "R1 after release",
          {busy, mem_req, atr_we}, 0);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] pg;
      logic       go;
      pg = VEC[i][12:5];
      stall = int'(VEC[i][4:1]);
      go = VEC[i][0];
      if (go) begin
        write_valid(pg);
        #1;
        check(busy && mem_req && (mem_addr == {pg, 8'h00}), "R2 start",
              {busy, mem_req, mem_addr}, {2'b11, pg, 8'h00});
        wait_done();
        check_copy("R4", pg);
        if (stall == 0) check(busy_cyc == 161, "R6 busy length", busy_cyc, 161);
      end else begin
        write_raw(pg);
        wr_cnt = 0;
        repeat (20) @(negedge clk);
        #1;
        check(!busy && (wr_cnt == 0), "R3 ignored when idle",
              {busy, 8'(wr_cnt)}, 0);
      end
    end

    // R5: ready held low holds the address and writes nothing
    stall = 15;
    write_valid(8'hC4);
    repeat (6) @(negedge clk);
    #1;
    check(busy && (mem_addr == 16'hC400) && (wr_cnt == 0), "R5 stall hold",
          mem_addr, 16'hC400);
    stall = 0;
    wait_done();
    check_copy("R5", 8'hC4);

    // R7: restart mid-copy with a new page
    stall = 1;
    write_valid(8'h90);
    while (wr_cnt < 50) @(negedge clk);
    write_valid(8'hB0);
    #1;
    check(mem_addr == 16'hB000, "R7 restart address", mem_addr, 16'hB000);
    wait_done();
    check_copy("R7", 8'hB0);

    // R3: out-of-window write during a copy is ignored
    stall = 0;
    write_valid(8'h88);
    while (wr_cnt < 30) @(negedge clk);
    write_raw(8'h20);
    wait_done();
    check_copy("R3 mid-copy", 8'h88);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule